// File: doc/BRIEF.md
# Expansion Bus Autoconfiguration Relocator

This block gives a 64 KB expansion card on a 16-bit expansion bus its plug-and-play identity. After reset the card is unconfigured. While the configuration-chain input is high, the card decodes the whole 64 KB page at the fixed configuration page `$E8`, and its local map is already live there. The low 128 bytes of the page hold a read-only descriptor. The host reads it one nibble at a time to learn the board type, size, vendor, product, serial number and ROM vector.

The host assigns the base address in two writes. A write to offset `$4A` sets the low nibble of the 8-bit page number, and it may be repeated freely. A write to offset `$48` supplies the high nibble and commits the relocation. From the next cycle the card answers only at its new page, and the chain output goes high so that the next board on the chain may configure. As an alternative, the host can write to offset `$4C` to shut the card up. The card then never answers again until reset, but it still passes the chain on.

The bus address is given as a word address `busAddr[23:1]`. Written and read nibbles travel on the upper nibble of the data bus, which appears here as 4-bit ports.

Top module: `autocfg_relocator`

## Requirements
- R1: After reset the card is unconfigured and `chainOut` is 0. With `chainIn` high, any strobed access whose page `busAddr[23:16]` equals `$E8` raises `cardSel` in the same cycle. Accesses to any other page do not.
- R2: While unconfigured with `chainIn` low, `cardSel` stays 0 for every address.
- R3: The descriptor holds 32 bytes. Byte n sits at byte offset 4n (high nibble) and 4n+2 (low nibble). The defined bytes are: byte 0 = `$D1`, byte 1 = product number (default 0), byte 2 = flags `$00`, bytes 4..5 = vendor `$12`,`$12`, bytes 6..9 = serial 0, bytes 10..11 = ROM vector `$10`,`$00`. All other bytes are `$00`.
- R4: On a selected read at an offset below `$80`, `rdNibble` carries the descriptor nibble. It is inverted except for byte 0 (offsets `$00` and `$02`). In every other case, including writes, offsets at or above `$80` and unselected cycles, `rdNibble` is 0.
- R5: A configuration write to offset `$4A` stores `wrNibble` as the low nibble of the base page. Repeats overwrite it and have no other effect: `chainOut` stays 0 and the card stays at `$E8`.
- R6: A configuration write to offset `$48` commits base page {`wrNibble`, stored low nibble}. In that cycle the card still decodes `$E8`. From the next cycle it answers only at the new page, and `chainOut` is 1.
- R7: Configuration offsets are compared on all of `busAddr[15:1]` and the page on all of `busAddr[23:16]`. A write to an alias such as `$1048` or `$0148` has no effect.
- R8: A configuration write to offset `$4C` shuts the card up. `cardSel` is 0 for every address until reset, and `chainOut` is 1.
- R9: Once the card is configured or shut up, writes to `$48`, `$4A` and `$4C` have no effect on the decode.
- R10: Reset returns a configured or shut-up card to the unconfigured state at `$E8` with `chainOut` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 23 | Word address, byte address bits 23..1 |
| strobe | input | 1 | Bus access valid this cycle |
| wrEn | input | 1 | Access is a write |
| wrNibble | input | 4 | Upper data nibble of a write |
| chainIn | input | 1 | Configuration chain from previous board |
| cardSel | output | 1 | Access decodes to this card |
| rdNibble | output | 4 | Descriptor nibble for the upper data nibble |
| chainOut | output | 1 | Configuration chain to next board |

## Verification
The committing write to `$48` and the address decode fall in the same cycle. The write is still decoded at the configuration page in that cycle, while the base register and state change at the edge that ends it. The bench holds the address at `$E80048` across that edge. It expects `cardSel` high just before the edge and low just after, and then sweeps all 256 pages to confirm that only the committed page answers. The same sweep after a shut-up write confirms that nothing answers.

// File: rtl/autocfg_pkg.sv
package autocfg_pkg;
  typedef enum logic [1:0] {
    ST_UNCONF = 2'd0,
    ST_CONFIG = 2'd1,
    ST_SHUT   = 2'd2
  } cfgState_t;

  typedef struct packed {
    logic ldLow;
    logic commit;
    logic shut;
  } cfgStrobe_t;

  // word offsets (byte offset >> 1) of the configuration registers
  localparam logic [14:0] OFS_BASE_HI = 15'h0024;
  localparam logic [14:0] OFS_BASE_LO = 15'h0025;
  localparam logic [14:0] OFS_SHUTUP  = 15'h0026;
endpackage

// File: rtl/autocfg_ctrl.sv
module autocfg_ctrl
  import autocfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        strobe,
  input  logic        wrEn,
  input  logic        chainIn,
  input  logic        winHit,
  input  logic [14:0] ofsWord,
  output cfgStrobe_t  stb,
  output cfgState_t   state,
  output logic        chainOut
);
  cfgState_t stateNext;
  logic cfgWrite;

  assign cfgWrite = strobe && wrEn && chainIn && winHit && (state == ST_UNCONF);

  always_comb begin
    stb.ldLow  = cfgWrite && (ofsWord == OFS_BASE_LO);
    stb.commit = cfgWrite && (ofsWord == OFS_BASE_HI);
    stb.shut   = cfgWrite && (ofsWord == OFS_SHUTUP);
  end

  always_comb begin
    stateNext = state;
    if (stb.commit)    stateNext = ST_CONFIG;
    else if (stb.shut) stateNext = ST_SHUT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_UNCONF;
    else       state <= stateNext;
  end

  assign chainOut = (state != ST_UNCONF);
endmodule

// File: rtl/autocfg_dpath.sv
module autocfg_dpath
  import autocfg_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter logic [7:0]  CFG_PAGE  = 8'hE8,
  parameter logic [15:0] VENDOR_ID = 16'h1212,
  parameter logic [7:0]  PRODUCT   = 8'd0,
  parameter logic [31:0] SERIAL    = 32'd0,
  parameter logic [15:0] ROM_VEC   = 16'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:1] busAddr,
  input  logic              strobe,
  input  logic              wrEn,
  input  logic [3:0]        wrNibble,
  input  logic              chainIn,
  input  cfgStrobe_t        stb,
  input  cfgState_t         state,
  output logic              winHit,
  output logic              cardSel,
  output logic [3:0]        rdNibble
);
  localparam int OFS_W  = 16;
  localparam int PAGE_W = ADDR_W - OFS_W;
  // type byte: bus type 11, no memlist, ROM vector valid, not chained, 64 KB
  localparam logic [7:0] TYPE_BYTE  = {2'b11, 1'b0, 1'b1, 1'b0, 3'b001};
  localparam logic [7:0] FLAGS_BYTE = 8'h00;

  logic [3:0]        baseLow;
  logic [PAGE_W-1:0] basePage;
  logic [PAGE_W-1:0] pageField;
  logic              baseHit;
  logic              selRaw;
  logic              inDesc;
  logic [4:0]        byteIdx;
  logic [7:0]        descByte;
  logic [3:0]        rawNib;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLow  <= '0;
      basePage <= '0;
    end else begin
      if (stb.ldLow)  baseLow  <= wrNibble;
      if (stb.commit) basePage <= PAGE_W'({wrNibble, baseLow});
    end
  end

  assign pageField = busAddr[ADDR_W-1:OFS_W];
  assign winHit    = (pageField == PAGE_W'(CFG_PAGE));
  assign baseHit   = (pageField == basePage);

  always_comb begin
    case (state)
      ST_UNCONF: selRaw = chainIn && winHit;
      ST_CONFIG: selRaw = baseHit;
      default:   selRaw = 1'b0;
    endcase
  end

  assign cardSel = strobe && selRaw;

  assign inDesc  = (busAddr[OFS_W-1:7] == '0);
  assign byteIdx = busAddr[6:2];

  always_comb begin
    case (byteIdx)
      5'd0:    descByte = TYPE_BYTE;
      5'd1:    descByte = PRODUCT;
      5'd2:    descByte = FLAGS_BYTE;
      5'd4:    descByte = VENDOR_ID[15:8];
      5'd5:    descByte = VENDOR_ID[7:0];
      5'd6:    descByte = SERIAL[31:24];
      5'd7:    descByte = SERIAL[23:16];
      5'd8:    descByte = SERIAL[15:8];
      5'd9:    descByte = SERIAL[7:0];
      5'd10:   descByte = ROM_VEC[15:8];
      5'd11:   descByte = ROM_VEC[7:0];
      default: descByte = 8'h00;
    endcase
  end

  assign rawNib   = busAddr[1] ? descByte[3:0] : descByte[7:4];
  assign rdNibble = (cardSel && !wrEn && inDesc)
                    ? ((byteIdx == 5'd0) ? rawNib : ~rawNib)
                    : 4'h0;
endmodule

// File: rtl/autocfg_relocator.sv
module autocfg_relocator
  import autocfg_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter logic [7:0]  CFG_PAGE  = 8'hE8,
  parameter logic [15:0] VENDOR_ID = 16'h1212,
  parameter logic [7:0]  PRODUCT   = 8'd0,
  parameter logic [31:0] SERIAL    = 32'd0,
  parameter logic [15:0] ROM_VEC   = 16'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:1] busAddr,
  input  logic              strobe,
  input  logic              wrEn,
  input  logic [3:0]        wrNibble,
  input  logic              chainIn,
  output logic              cardSel,
  output logic [3:0]        rdNibble,
  output logic              chainOut
);
  cfgStrobe_t stb;
  cfgState_t  state;
  logic       winHit;

  autocfg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrEn     (wrEn),
    .chainIn  (chainIn),
    .winHit   (winHit),
    .ofsWord  (busAddr[15:1]),
    .stb      (stb),
    .state    (state),
    .chainOut (chainOut)
  );

  autocfg_dpath #(
    .ADDR_W    (ADDR_W),
    .CFG_PAGE  (CFG_PAGE),
    .VENDOR_ID (VENDOR_ID),
    .PRODUCT   (PRODUCT),
    .SERIAL    (SERIAL),
    .ROM_VEC   (ROM_VEC)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .strobe   (strobe),
    .wrEn     (wrEn),
    .wrNibble (wrNibble),
    .chainIn  (chainIn),
    .stb      (stb),
    .state    (state),
    .winHit   (winHit),
    .cardSel  (cardSel),
    .rdNibble (rdNibble)
  );
endmodule

// File: rtl/autocfg_checker.sv
module autocfg_checker #(
  parameter int         ADDR_W   = 24,
  parameter logic [7:0] CFG_PAGE = 8'hE8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:1] busAddr,
  input logic              strobe,
  input logic              wrEn,
  input logic              chainIn,
  input logic              cardSel,
  input logic [3:0]        rdNibble,
  input logic              chainOut
);
  // R9: a configured or shut-up card never returns to unconfigured
  a_r9_chain_sticky: assert property (@(posedge clk) disable iff (!rstN)
    chainOut |=> chainOut);

  // R1: unconfigured card answers only in the configuration page
  a_r1_window_only: assert property (@(posedge clk) disable iff (!rstN)
    (!chainOut && cardSel) |-> (busAddr[ADDR_W-1:16] == (ADDR_W-16)'(CFG_PAGE)));

  // R2: blocked chain keeps an unconfigured card silent
  a_r2_chain_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!chainOut && !chainIn) |-> !cardSel);

  // R4: no descriptor data outside a selected read
  a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    (!cardSel || wrEn) |-> (rdNibble == 4'h0));

  // R6: leaving the unconfigured state needs a strobed write
  a_r6_commit_by_write: assert property (@(posedge clk) disable iff (!rstN)
    (!chainOut ##1 chainOut) |-> $past(strobe && wrEn));

  // R1: selection only during a strobe
  a_r1_sel_strobe: assert property (@(posedge clk) disable iff (!rstN)
    cardSel |-> strobe);
endmodule

bind autocfg_relocator autocfg_checker #(.ADDR_W(ADDR_W), .CFG_PAGE(CFG_PAGE)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .strobe(strobe), .wrEn(wrEn),
  .chainIn(chainIn), .cardSel(cardSel), .rdNibble(rdNibble), .chainOut(chainOut)
);

// File: tb/autocfg_relocator_tb.sv
module autocfg_relocator_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [23:1] busAddr = '0;
  logic        strobe = 0;
  logic        wrEn = 0;
  logic [3:0]  wrNibble = '0;
  logic        chainIn = 1;
  logic        cardSel;
  logic [3:0]  rdNibble;
  logic        chainOut;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  autocfg_relocator u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .strobe(strobe), .wrEn(wrEn),
    .wrNibble(wrNibble), .chainIn(chainIn), .cardSel(cardSel),
    .rdNibble(rdNibble), .chainOut(chainOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int n);
    case (n)
      0: return 8'hD1;
      4, 5: return 8'h12;
      10: return 8'h10;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] expNib(input int ofs);
    logic [7:0] b;
    logic [3:0] nb;
    b  = expByte(ofs / 4);
    nb = ((ofs % 4) == 2) ? b[3:0] : b[7:4];
    return (ofs < 4) ? nb : ~nb;
  endfunction

  task automatic rd(input logic [23:0] a);
    @(negedge clk);
    strobe = 1; wrEn = 0; busAddr = a[23:1];
    #1;
  endtask

  task automatic wr(input logic [23:0] a, input logic [3:0] n);
    @(negedge clk);
    strobe = 1; wrEn = 1; busAddr = a[23:1]; wrNibble = n;
    @(negedge clk);
    strobe = 0; wrEn = 0;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; strobe = 0; wrEn = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
    #1;
  endtask

  task automatic sweep(input string tag, input int hitPage);
    for (int p = 0; p < 256; p++) begin
      rd({p[7:0], 16'h0010});
      chk(tag, int'(cardSel), int'(p == hitPage));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    chk("R1 reset chainOut", int'(chainOut), 0);
    rd(24'hE80000);
    chk("R1 window select", int'(cardSel), 1);
    rd(24'hE90000);
    chk("R1 other page", int'(cardSel), 0);

    for (int o = 0; o < 128; o += 2) begin
      rd(24'hE80000 + 24'(o));
      chk($sformatf("R3 R4 nibble ofs %0h", o), int'(rdNibble), int'(expNib(o)));
    end
    rd(24'hE80080);
    chk("R4 beyond descriptor", int'(rdNibble), 0);

    chainIn = 0;
    rd(24'hE80000);
    chk("R2 chain low", int'(cardSel), 0);
    chainIn = 1;

    wr(24'hE81048, 4'h5);
    wr(24'hE80148, 4'h6);
    chk("R7 alias no commit", int'(chainOut), 0);
    rd(24'hE80000);
    chk("R7 still at window", int'(cardSel), 1);

    wr(24'hE8004A, 4'h3);
    wr(24'hE8004A, 4'h7);
    chk("R5 low write no commit", int'(chainOut), 0);
    rd(24'hE80000);
    chk("R5 still at window", int'(cardSel), 1);

    // commit, observed on both sides of the edge
    @(negedge clk);
    strobe = 1; wrEn = 1; busAddr = 24'hE80048 >> 1; wrNibble = 4'h4;
    #1;
    chk("R6 commit cycle old window", int'(cardSel), 1);
    @(posedge clk); #1;
    chk("R6 left window", int'(cardSel), 0);
    chk("R6 chainOut", int'(chainOut), 1);
    @(negedge clk);
    strobe = 0; wrEn = 0;
    sweep("R6 page sweep", 8'h47);

    wr(24'h470048, 4'h9);
    wr(24'h47004A, 4'h1);
    wr(24'h47004C, 4'h0);
    rd(24'h470000);
    chk("R9 base kept", int'(cardSel), 1);
    rd(24'h970000);
    chk("R9 no new base", int'(cardSel), 0);

    doReset();
    chk("R10 chainOut cleared", int'(chainOut), 0);
    rd(24'hE80000);
    chk("R10 back at window", int'(cardSel), 1);
    rd(24'h470000);
    chk("R10 old base gone", int'(cardSel), 0);

    wr(24'hE8004C, 4'h0);
    chk("R8 shut chainOut", int'(chainOut), 1);
    wr(24'hE80048, 4'h2);
    sweep("R8 R9 shut sweep", -1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule